// File: doc/BRIEF.md
# Round-Robin Hardware Monitor Sequencer

This block schedules measurements for a system health monitor. It steps an external converter through seven channels in a fixed order, starting one conversion on each slow sample tick. The channels are core voltage 2, +12 V, +5 V, +3.3 V, +2.5 V, core voltage 1 and the on-die temperature. Each finished result goes into the value register of its channel. The result is then compared with that channel's high and low limits, and any violation is latched in a sticky status bit. An open-drain interrupt, modelled as a pull-low enable, is raised while any unmasked status bit is set. Software reaches every register through a simple strobe read/write port.

The sequencer is a four-state machine:

- IDLE: not running, channel pointer held at 0.
- WAIT: waiting for the next sample tick.
- CONV: a conversion is in flight.
- STORE: the captured result is committed and checked.

Transitions:

- IDLE→WAIT when the run condition becomes true.
- WAIT→CONV on a tick, which also emits the start pulse.
- CONV→STORE when the converter reports done.
- STORE→WAIT after the commit, with the channel advancing and wrapping from 6 to 0.
- Any state→IDLE as soon as the run condition drops. An in-flight result is discarded on this path.

Top module: `hwmon_seq`

## Requirements
- R1: Sampling runs only while configuration (address 0x00) bit 0 is 1 and bit 3 is 0. While either condition fails, `adc_start` never pulses.
- R2: `irq_pull` can be 1 only while configuration bit 1 is 1 and bit 3 is 0. Forcing bit 3 to 1 drops it within two cycles, and clearing bit 3 brings it back while status is still pending.
- R3: Channel codes on `adc_chan` follow the order 0 (core 2), 1 (+12 V), 2 (+5 V), 3 (+3.3 V), 4 (+2.5 V), 5 (core 1), 6 (temperature).
- R4: One conversion starts per sample tick, every TICK_DIV clock cycles, as a one-cycle `adc_start` pulse. After channel 6 the order wraps to channel 0.
- R5: The result sampled with `adc_done` is readable at address 0x08+channel from the second clock edge after `adc_done`.
- R6: The high limit sits at 0x10+2·channel and the low limit at 0x11+2·channel. A result strictly above the high limit or strictly below the low limit sets status bit [channel] (address 0x01). A result equal to either limit sets nothing. Status bits stay set until read.
- R7: Channel 6 is compared as two's-complement signed; channels 0–5 are compared unsigned.
- R8: Reading status returns the pending bits and clears exactly those bits. The interrupt then falls if nothing else is pending.
- R9: Mask register (address 0x02) bit [channel]=1 keeps that channel's status out of the interrupt. The status bit itself is still set.
- R10: Clearing configuration bit 0 while a conversion is in flight discards its result. The next run begins at channel 0.
- R11: After reset, configuration, status, mask and the interrupt are 0. Voltage limits are high 0xFF and low 0x00. The temperature limits are high 0x7F and low 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adc_start | output | 1 | One-cycle conversion start pulse |
| adc_chan | output | 3 | Channel code for the converter |
| adc_done | input | 1 | Conversion complete, qualifies adc_data |
| adc_data | input | DATA_W | Conversion result |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status when reading it) |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from reg_addr |
| irq_pull | output | 1 | Drive-low enable of the open-drain interrupt pin |

## Verification
The hardest situation to reach is a stop while a conversion is in flight. The bench waits for a start pulse, writes the configuration with bit 0 cleared in the very next cycle, and only then returns a done pulse carrying data that differs from the stored value. It then checks that the value register kept its old contents and that the restarted run opens on channel 0. Every conversion in the sweep is driven with data chosen to sit exactly on, one step past, or well away from each limit. This exercises both signed and unsigned comparisons, with the expected flag computed in the bench from the programmed limits.

// File: rtl/hwmon_pkg.sv
package hwmon_pkg;
    localparam int NUM_CH = 7;
    localparam int CH_W   = 3;
    localparam int ADDR_W = 5;

    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);
    localparam logic [CH_W-1:0] TEMP_CH = CH_W'(NUM_CH - 1);

    localparam logic [ADDR_W-1:0] A_CFG  = 5'h00;
    localparam logic [ADDR_W-1:0] A_STAT = 5'h01;
    localparam logic [ADDR_W-1:0] A_MASK = 5'h02;

    localparam int CFG_GO   = 0;
    localparam int CFG_IEN  = 1;
    localparam int CFG_ICLR = 3;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT,
        S_CONV,
        S_STORE
    } seq_state_e;
endpackage

// File: rtl/hwmon_tick.sv
module hwmon_tick #(
    parameter int TICK_DIV = 4444
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || cnt_q == CNT_LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CW'(1);
    end

    assign tick = run && (cnt_q == CNT_LAST);

    // Counter restarts from zero whenever sampling is halted.
    p_tick_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);
endmodule

// File: rtl/hwmon_fsm.sv
module hwmon_fsm
    import hwmon_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              adc_done,
    input  logic [DATA_W-1:0] adc_data,
    output logic              adc_start,
    output logic [CH_W-1:0]   chan,
    output logic              commit,
    output logic [DATA_W-1:0] sample
);
    seq_state_e        state_q, state_d;
    logic [CH_W-1:0]   chan_q, chan_d;
    logic [DATA_W-1:0] sample_q;

    always_comb begin
        state_d = state_q;
        chan_d  = chan_q;
        if (!run) begin
            state_d = S_IDLE;
            chan_d  = '0;
        end else begin
            unique case (state_q)
                S_IDLE:  state_d = S_WAIT;
                S_WAIT:  if (tick) state_d = S_CONV;
                S_CONV:  if (adc_done) state_d = S_STORE;
                S_STORE: begin
                    state_d = S_WAIT;
                    chan_d  = (chan_q == LAST_CH) ? '0 : chan_q + CH_W'(1);
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            chan_q   <= '0;
            sample_q <= '0;
        end else begin
            state_q <= state_d;
            chan_q  <= chan_d;
            if (state_q == S_CONV && adc_done)
                sample_q <= adc_data;
        end
    end

    always_comb begin
        adc_start = (state_q == S_WAIT) && tick;
        commit    = (state_q == S_STORE) && run;
        chan      = chan_q;
        sample    = sample_q;
    end

    p_halt_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> state_q == S_IDLE);
    p_chan_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chan_q <= LAST_CH);
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && chan_q == LAST_CH) |=> chan_q == '0);
    p_start_conv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> (state_q == S_CONV || !run));
    p_idle_ch0_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_IDLE |-> chan_q == '0);
endmodule

// File: rtl/hwmon_regs.sv
module hwmon_regs
    import hwmon_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              commit,
    input  logic [CH_W-1:0]   chan,
    input  logic [DATA_W-1:0] sample,
    output logic              run,
    output logic              irq_pull
);
    logic              cfg_go, cfg_ien, cfg_iclr;
    logic [NUM_CH-1:0] stat_q, mask_q, ev_vec, clr_vec;
    logic [DATA_W-1:0] val_q [NUM_CH];
    logic [DATA_W-1:0] hi_q  [NUM_CH];
    logic [DATA_W-1:0] lo_q  [NUM_CH];
    logic              irq_q, viol;

    logic              val_hit, lim_hit;
    logic [CH_W-1:0]   val_idx, lim_idx;

    assign val_idx = reg_addr[CH_W-1:0];
    assign lim_idx = reg_addr[CH_W:1];
    assign val_hit = (reg_addr[4:3] == 2'b01) && (val_idx <= LAST_CH);
    assign lim_hit = reg_addr[4] && (lim_idx <= LAST_CH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_go   <= 1'b0;
            cfg_ien  <= 1'b0;
            cfg_iclr <= 1'b0;
            mask_q   <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_CFG) begin
                cfg_go   <= reg_wdata[CFG_GO];
                cfg_ien  <= reg_wdata[CFG_IEN];
                cfg_iclr <= reg_wdata[CFG_ICLR];
            end
            if (reg_addr == A_MASK)
                mask_q <= reg_wdata[NUM_CH-1:0];
        end
    end

    assign run = cfg_go && !cfg_iclr;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lim
        localparam logic [DATA_W-1:0] HI_RST = (g == int'(TEMP_CH)) ?
            {1'b0, {(DATA_W-1){1'b1}}} : {DATA_W{1'b1}};
        localparam logic [DATA_W-1:0] LO_RST = (g == int'(TEMP_CH)) ?
            {1'b1, {(DATA_W-1){1'b0}}} : {DATA_W{1'b0}};
        logic [DATA_W-1:0] hi_r, lo_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hi_r <= HI_RST;
                lo_r <= LO_RST;
            end else if (reg_wr && lim_hit && lim_idx == CH_W'(g)) begin
                if (reg_addr[0]) lo_r <= reg_wdata;
                else             hi_r <= reg_wdata;
            end
        end

        assign hi_q[g] = hi_r;
        assign lo_q[g] = lo_r;
    end

    always_comb begin
        if (chan == TEMP_CH)
            viol = ($signed(sample) > $signed(hi_q[chan])) ||
                   ($signed(sample) < $signed(lo_q[chan]));
        else
            viol = (sample > hi_q[chan]) || (sample < lo_q[chan]);
        ev_vec = '0;
        if (commit && viol)
            ev_vec[chan] = 1'b1;
        clr_vec = (reg_rd && reg_addr == A_STAT) ? stat_q : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++)
                val_q[i] <= '0;
            stat_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (commit)
                val_q[chan] <= sample;
            stat_q <= (stat_q & ~clr_vec) | ev_vec;
            irq_q  <= cfg_ien && !cfg_iclr && |(stat_q & ~mask_q);
        end
    end

    assign irq_pull = irq_q;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CFG) begin
            reg_rdata[CFG_GO]   = cfg_go;
            reg_rdata[CFG_IEN]  = cfg_ien;
            reg_rdata[CFG_ICLR] = cfg_iclr;
        end else if (reg_addr == A_STAT) begin
            reg_rdata[NUM_CH-1:0] = stat_q;
        end else if (reg_addr == A_MASK) begin
            reg_rdata[NUM_CH-1:0] = mask_q;
        end else if (val_hit) begin
            reg_rdata = val_q[val_idx];
        end else if (lim_hit) begin
            reg_rdata = reg_addr[0] ? lo_q[lim_idx] : hi_q[lim_idx];
        end
    end

    p_irq_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pull |-> $past(cfg_ien && !cfg_iclr));
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_addr == A_STAT) |=> (stat_q & $past(stat_q)) == $past(stat_q));
    p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pull |-> $past((stat_q & ~mask_q) != '0));
    p_commit_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> val_q[$past(chan)] == $past(sample));
endmodule

// File: rtl/hwmon_seq.sv
module hwmon_seq
    import hwmon_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int TICK_DIV = 4444
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              adc_start,
    output logic [CH_W-1:0]   adc_chan,
    input  logic              adc_done,
    input  logic [DATA_W-1:0] adc_data,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_pull
);
    logic              run, tick, commit;
    logic [CH_W-1:0]   chan;
    logic [DATA_W-1:0] sample;

    hwmon_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    hwmon_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .tick      (tick),
        .adc_done  (adc_done),
        .adc_data  (adc_data),
        .adc_start (adc_start),
        .chan      (chan),
        .commit    (commit),
        .sample    (sample)
    );

    hwmon_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .commit    (commit),
        .chan      (chan),
        .sample    (sample),
        .run       (run),
        .irq_pull  (irq_pull)
    );

    assign adc_chan = chan;
endmodule

// File: tb/hwmon_seq_tb.sv
module hwmon_seq_tb;
    localparam int TDIV = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       adc_start;
    logic [2:0] adc_chan;
    logic       adc_done = 1'b0;
    logic [7:0] adc_data = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_pull;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int last_t = 0;
    int last_gap = 0;
    int n_starts = 0;
    int exp_ch = 0;
    logic [7:0] hi_l [7];
    logic [7:0] lo_l [7];
    logic [7:0] exp_val [7];
    logic [6:0] mask_m = '0;

    always #5 clk = ~clk;

    hwmon_seq #(.DATA_W(8), .TICK_DIV(TDIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .adc_start(adc_start), .adc_chan(adc_chan),
        .adc_done(adc_done), .adc_data(adc_data), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_pull(irq_pull)
    );

    always @(negedge clk) begin
        cyc++;
        if (adc_start) begin
            n_starts++;
            last_gap = cyc - last_t;
            last_t = cyc;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_start();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!adc_start && n < 2000);
        if (!adc_start) chk("R4 start pulse", 0, 1);
    endtask

    function automatic bit viol_f(int ch, logic [7:0] d);
        if (ch == 6) return ($signed(d) > $signed(hi_l[ch])) || ($signed(d) < $signed(lo_l[ch]));
        return (d > hi_l[ch]) || (d < lo_l[ch]);
    endfunction

    function automatic logic [7:0] pick(int k, int ch);
        case (k % 5)
            0: return hi_l[ch];
            1: return hi_l[ch] + 8'd1;
            2: return lo_l[ch];
            3: return lo_l[ch] - 8'd1;
            default: return 8'((k * 73 + 11) & 255);
        endcase
    endfunction

    task automatic conv(input int k, input bit rd_stat, input bit gap_chk, input string tag);
        int ch;
        logic [7:0] d, r;
        bit v;
        wait_start();
        ch = int'(adc_chan);
        chk({tag, " channel order"}, adc_chan, exp_ch);
        d = pick(k, ch);
        repeat (3) @(negedge clk);
        adc_done = 1'b1; adc_data = d;
        @(negedge clk);
        adc_done = 1'b0;
        repeat (3) @(negedge clk);
        if (gap_chk) chk("R4 tick spacing", last_gap, TDIV);
        rd(5'h08 + 5'(ch), r);
        chk("R5 value register", r, d);
        exp_val[ch] = d;
        v = viol_f(ch, d);
        chk("R9 irq vs mask", irq_pull, v && !mask_m[ch]);
        if (rd_stat) begin
            rd(5'h01, r);
            chk(ch == 6 ? "R7 signed status" : "R6 status", r, 32'(v) << ch);
            rd(5'h01, r);
            chk("R8 read clears", r, 0);
            repeat (2) @(negedge clk);
            chk("R8 irq falls", irq_pull, 0);
        end
        exp_ch = (exp_ch + 1) % 7;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        int s0;
        for (int c = 0; c < 7; c++) exp_val[c] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        chk("R11 irq reset", irq_pull, 0);
        rd(5'h00, r); chk("R11 cfg reset", r, 0);
        rd(5'h01, r); chk("R11 status reset", r, 0);
        rd(5'h02, r); chk("R11 mask reset", r, 0);
        for (int c = 0; c < 7; c++) begin
            rd(5'h10 + 5'(2 * c), r); chk("R11 high reset", r, c == 6 ? 8'h7F : 8'hFF);
            rd(5'h11 + 5'(2 * c), r); chk("R11 low reset", r, c == 6 ? 8'h80 : 8'h00);
        end

        // program limits
        for (int c = 0; c < 7; c++) begin
            hi_l[c] = (c == 6) ? 8'h19 : 8'(8'hB0 + 4 * c);
            lo_l[c] = (c == 6) ? 8'hF6 : 8'(8'h30 + 2 * c);
            wr(5'h10 + 5'(2 * c), hi_l[c]);
            wr(5'h11 + 5'(2 * c), lo_l[c]);
        end
        for (int c = 0; c < 7; c++) begin
            rd(5'h10 + 5'(2 * c), r); chk("R6 high readback", r, hi_l[c]);
            rd(5'h11 + 5'(2 * c), r); chk("R6 low readback", r, lo_l[c]);
        end

        // idle: no sampling
        s0 = n_starts;
        repeat (100) @(negedge clk);
        chk("R1 idle no start", n_starts - s0, 0);

        // continuous run, unmasked
        wr(5'h00, 8'h03);
        rd(5'h00, r); chk("R1 cfg readback", r, 8'h03);
        for (int k = 0; k < 35; k++) conv(k, 1'b1, k > 0, "R3");

        // masked run
        mask_m = 7'h55;
        wr(5'h02, 8'h55);
        rd(5'h02, r); chk("R9 mask readback", r, 8'h55);
        for (int k = 35; k < 56; k++) conv(k, 1'b1, 1'b0, "R4");
        mask_m = '0;
        wr(5'h02, 8'h00);

        // stop in the middle of a conversion
        wait_start();
        begin
            int ch = int'(adc_chan);
            wr(5'h00, 8'h02);
            adc_done = 1'b1; adc_data = ~exp_val[ch];
            @(negedge clk);
            adc_done = 1'b0;
            repeat (4) @(negedge clk);
            rd(5'h08 + 5'(ch), r);
            chk("R10 discarded result", r, exp_val[ch]);
        end
        s0 = n_starts;
        repeat (60) @(negedge clk);
        chk("R1 stopped no start", n_starts - s0, 0);

        // restart begins at channel 0; leave a violation pending
        exp_ch = 0;
        wr(5'h00, 8'h03);
        conv(1, 1'b0, 1'b0, "R10");

        // interrupt clear forces irq off and halts sampling
        wr(5'h00, 8'h0B);
        repeat (3) @(negedge clk);
        chk("R2 irq forced off", irq_pull, 0);
        s0 = n_starts;
        repeat (80) @(negedge clk);
        chk("R1 clear halts sampling", n_starts - s0, 0);
        wr(5'h00, 8'h01);
        repeat (3) @(negedge clk);
        chk("R2 irq disabled", irq_pull, 0);
        wr(5'h00, 8'h03);
        repeat (3) @(negedge clk);
        chk("R2 irq returns", irq_pull, 1);
        rd(5'h01, r);
        chk("R6 sticky status", r, 8'h01);
        wr(5'h00, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule